// File: doc/BRIEF.md
# Maskable Interrupt Controller with Idle Bypass

This block collects 32 level-sensitive interrupt request lines into a pending register, qualifies each pending bit with a software-writable mask bit, and steers every resulting active interrupt onto one of two processor lines. A per-source level bit picks the line: the normal interrupt (`irq_o`) or the fast interrupt (`fiq_o`). Software can read the pending bits at any time, masked or not. This lets it poll sources without being interrupted by them. It can also hold off lower-priority sources while it services another one.

An idle-mode input and a one-bit control field set what happens while the system sleeps. When the control bit is clear and `idle_i` is high, every mask bit is ignored. Any pending request then reaches an output, so any source can wake the processor. When the control bit is set, masking stays in force during idle.

Registers sit behind a simple single-cycle read/write port that uses a 2-bit word index. The mask register has no reset value, so software must program it before it relies on the outputs.

Top module: `ictl_top`

## Requirements
- R1: Each clock edge copies `req_i` into the pending register, one bit per source. Software can read the pending register at word index 0, whatever the mask holds.
- R2: Outside the idle bypass, a pending bit drives an output only if its mask bit (word index 1) is 1. A pending bit whose mask bit is 0 drives neither `irq_o` nor `fiq_o`.
- R3: When `idle_i` is 1 and control bit 0 (word index 3) is 0, the mask is ignored and every pending bit drives an output.
- R4: When control bit 0 is 1, masking applies in idle exactly as it does outside idle.
- R5: Level register bit n (word index 2) routes source n. A value of 0 sends it to `irq_o` and a value of 1 sends it to `fiq_o`. `irq_o` is the OR of the active bits whose level is 0, and `fiq_o` is the OR of the active bits whose level is 1.
- R6: A read with `rd_en_i` high returns the selected register on `rdata_o` one cycle later. The selections are: index 0 pending, 1 mask, 2 level, 3 control (bits 31:1 read 0). In a cycle after no read, `rdata_o` is 0.
- R7: A write with `wr_en_i` high updates the selected register at that edge. A write to index 0 has no effect on the pending register.
- R8: After reset, level, control, pending and `rdata_o` are 0. The mask is not reset.
- R9: `irq_o` and `fiq_o` follow `idle_i` and the register state with no added delay. A change on `req_i` reaches them after one clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_i | input | 32 | Level-sensitive interrupt requests |
| idle_i | input | 1 | System is in idle mode |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 2 | Register word index |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after a read |
| irq_o | output | 1 | Normal interrupt to the processor |
| fiq_o | output | 1 | Fast interrupt to the processor |

## Verification
A request change is due on the outputs one edge later, so the bench samples 1 ns after the edge that captures it. A register write is visible in that same post-edge window. A change on `idle_i` needs no edge: the bench checks it 1 ns after driving it, and it also confirms that the outputs have not yet moved after a request change that has not been clocked. Read data is compared 1 ns after the edge that follows the read strobe. The expected value for a pending read is the model's pending value from before that edge.

// File: rtl/ictl_pkg.sv
package ictl_pkg;
  typedef enum logic [1:0] {
    SEL_PEND  = 2'd0,
    SEL_MASK  = 2'd1,
    SEL_LEVEL = 2'd2,
    SEL_CTRL  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/ictl_rst_sync.sv
module ictl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sn = chain_q[STAGES-1];
endmodule

// File: rtl/ictl_pend.sv
module ictl_pend #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_sn,
  input  logic [N-1:0] req_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] pend_q;
  logic [N-1:0] pend_d;
  logic         pend_en;

  always_comb begin
    pend_en = 1'b1;
    pend_d  = req_i;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)      pend_q <= '0;
    else if (pend_en) pend_q <= pend_d;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/ictl_regs.sv
module ictl_regs
  import ictl_pkg::*;
#(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_sn,
  input  logic         wr_en_i,
  input  logic         rd_en_i,
  input  logic [1:0]   addr_i,
  input  logic [N-1:0] wdata_i,
  input  logic [N-1:0] pend_i,
  output logic [N-1:0] mask_o,
  output logic [N-1:0] level_o,
  output logic         dim_o,
  output logic [N-1:0] rdata_o
);
  reg_sel_e     sel;
  logic [N-1:0] mask_q,  mask_d;
  logic [N-1:0] level_q, level_d;
  logic         dim_q,   dim_d;
  logic [N-1:0] rdata_q, rdata_d;
  logic         mask_en, level_en, dim_en;

  always_comb begin
    sel      = reg_sel_e'(addr_i);
    mask_en  = wr_en_i && (sel == SEL_MASK);
    level_en = wr_en_i && (sel == SEL_LEVEL);
    dim_en   = wr_en_i && (sel == SEL_CTRL);
    mask_d   = wdata_i;
    level_d  = wdata_i;
    dim_d    = wdata_i[0];
    rdata_d  = '0;
    if (rd_en_i) begin
      unique case (sel)
        SEL_PEND:  rdata_d = pend_i;
        SEL_MASK:  rdata_d = mask_q;
        SEL_LEVEL: rdata_d = level_q;
        SEL_CTRL:  rdata_d = {{(N-1){1'b0}}, dim_q};
        default:   rdata_d = '0;
      endcase
    end
  end

  // mask has no reset by intent: software owns its first value
  always_ff @(posedge clk) begin
    if (mask_en) mask_q <= mask_d;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      level_q <= '0;
      dim_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (level_en) level_q <= level_d;
      if (dim_en)   dim_q   <= dim_d;
      rdata_q <= rdata_d;
    end
  end

  assign mask_o  = mask_q;
  assign level_o = level_q;
  assign dim_o   = dim_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/ictl_route.sv
module ictl_route #(
  parameter int N = 32
) (
  input  logic [N-1:0] pend_i,
  input  logic [N-1:0] mask_i,
  input  logic [N-1:0] level_i,
  input  logic         dim_i,
  input  logic         idle_i,
  output logic         irq_o,
  output logic         fiq_o
);
  logic         bypass;
  logic [N-1:0] to_irq, to_fiq;

  assign bypass = idle_i & ~dim_i;

  for (genvar g = 0; g < N; g++) begin : g_src
    logic act;
    assign act       = pend_i[g] & (mask_i[g] | bypass);
    assign to_irq[g] = act & ~level_i[g];
    assign to_fiq[g] = act &  level_i[g];
  end

  assign irq_o = |to_irq;
  assign fiq_o = |to_fiq;
endmodule

// File: rtl/ictl_top.sv
module ictl_top #(
  parameter int NSRC       = 32,
  parameter int SYNC_STAGE = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] req_i,
  input  logic            idle_i,
  input  logic            wr_en_i,
  input  logic            rd_en_i,
  input  logic [1:0]      addr_i,
  input  logic [NSRC-1:0] wdata_i,
  output logic [NSRC-1:0] rdata_o,
  output logic            irq_o,
  output logic            fiq_o
);
  logic            rst_sn;
  logic [NSRC-1:0] pend, mask, level;
  logic            dim;

  ictl_rst_sync #(.STAGES(SYNC_STAGE)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sn(rst_sn)
  );

  ictl_pend #(.N(NSRC)) u_pend (
    .clk(clk), .rst_sn(rst_sn), .req_i(req_i), .pend_o(pend)
  );

  ictl_regs #(.N(NSRC)) u_regs (
    .clk(clk), .rst_sn(rst_sn), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .pend_i(pend),
    .mask_o(mask), .level_o(level), .dim_o(dim), .rdata_o(rdata_o)
  );

  ictl_route #(.N(NSRC)) u_route (
    .pend_i(pend), .mask_i(mask), .level_i(level), .dim_i(dim),
    .idle_i(idle_i), .irq_o(irq_o), .fiq_o(fiq_o)
  );
endmodule

// File: rtl/ictl_chk.sv
module ictl_chk #(
  parameter int N = 32
) (
  input logic         clk,
  input logic         rst_sn,
  input logic [N-1:0] req_i,
  input logic         idle_i,
  input logic         rd_en_i,
  input logic [1:0]   addr_i,
  input logic [N-1:0] rdata_o,
  input logic         irq_o,
  input logic         fiq_o,
  input logic [N-1:0] pend,
  input logic [N-1:0] mask,
  input logic [N-1:0] level,
  input logic         dim
);
  logic bypass;
  assign bypass = idle_i && !dim;

  // R1: pending follows the request lines after one edge
  a_r1_pend_follows: assert property (@(posedge clk) disable iff (!rst_sn)
    1'b1 |=> pend == $past(req_i));

  // R2, R4: with masking in force, nothing masked reaches an output
  a_r2_masked_quiet: assert property (@(posedge clk) disable iff (!rst_sn)
    (!bypass && ((pend & mask) == '0)) |-> (!irq_o && !fiq_o));

  // R3: idle bypass makes any pending bit visible
  a_r3_idle_wake: assert property (@(posedge clk) disable iff (!rst_sn)
    (bypass && (pend != '0)) |-> (irq_o || fiq_o));

  // R5: a fast-routed unmasked pending bit raises fiq_o
  a_r5_fast_route: assert property (@(posedge clk) disable iff (!rst_sn)
    ((pend & mask & level) != '0) |-> fiq_o);

  // R5: a normal-routed unmasked pending bit raises irq_o
  a_r5_norm_route: assert property (@(posedge clk) disable iff (!rst_sn)
    ((pend & mask & ~level) != '0) |-> irq_o);

  // R6: mask readback one cycle later
  a_r6_mask_read: assert property (@(posedge clk) disable iff (!rst_sn)
    (rd_en_i && addr_i == 2'd1) |=> rdata_o == $past(mask));

  // R6: no read gives zero data
  a_r6_idle_bus: assert property (@(posedge clk) disable iff (!rst_sn)
    !rd_en_i |=> rdata_o == '0);
endmodule

bind ictl_top ictl_chk #(.N(NSRC)) u_chk (
  .clk(clk), .rst_sn(rst_sn), .req_i(req_i), .idle_i(idle_i),
  .rd_en_i(rd_en_i), .addr_i(addr_i), .rdata_o(rdata_o),
  .irq_o(irq_o), .fiq_o(fiq_o), .pend(pend), .mask(mask),
  .level(level), .dim(dim)
);

// File: tb/tb_ictl_top.sv
`timescale 1ns/1ps
module tb_ictl_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] req_i;
  logic        idle_i;
  logic        wr_en_i, rd_en_i;
  logic [1:0]  addr_i;
  logic [31:0] wdata_i;
  logic [31:0] rdata_o;
  logic        irq_o, fiq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [31:0] m_pend, m_mask, m_level;
  logic        m_dim;

  always #2.5 clk = ~clk;

  ictl_top dut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .idle_i(idle_i),
    .wr_en_i(wr_en_i), .rd_en_i(rd_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o), .fiq_o(fiq_o)
  );

  function automatic logic exp_line(input logic fast);
    logic [31:0] act;
    act = m_pend & (m_mask | {32{idle_i & ~m_dim}});
    return fast ? |(act & m_level) : |(act & ~m_level);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_out(input string tag);
    check({tag, " irq"}, {31'b0, irq_o}, {31'b0, exp_line(1'b0)});
    check({tag, " fiq"}, {31'b0, fiq_o}, {31'b0, exp_line(1'b1)});
  endtask

  task automatic cyc();
    @(posedge clk); #1;
    m_pend = req_i;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    wr_en_i = 1'b1; addr_i = sel; wdata_i = d;
    cyc();
    wr_en_i = 1'b0;
    case (sel)
      2'd1: m_mask  = d;
      2'd2: m_level = d;
      2'd3: m_dim   = d[0];
      default: ;
    endcase
  endtask

  task automatic rd(input logic [1:0] sel, input string tag);
    logic [31:0] e;
    case (sel)
      2'd0: e = m_pend;
      2'd1: e = m_mask;
      2'd2: e = m_level;
      default: e = {31'b0, m_dim};
    endcase
    rd_en_i = 1'b1; addr_i = sel;
    cyc();
    rd_en_i = 1'b0;
    check(tag, rdata_o, e);
  endtask

  initial begin
    rst_n = 1'b0; req_i = '0; idle_i = 1'b0; wr_en_i = 1'b0; rd_en_i = 1'b0;
    addr_i = '0; wdata_i = '0;
    m_pend = '0; m_mask = '0; m_level = '0; m_dim = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) cyc();

    // R8 reset state
    check("R8 rdata after reset", rdata_o, 32'h0);
    rd(2'd2, "R8 level reset");
    rd(2'd3, "R8 ctrl reset");
    rd(2'd0, "R8 pending reset");

    // program mask first, it has no reset value
    wr(2'd1, 32'h0000_00F0);
    wr(2'd2, 32'h0000_0030);
    rd(2'd1, "R7 mask write");

    // R2 masked source quiet, R1 still visible
    req_i = 32'h1; cyc();
    check_out("R2 masked");
    check("R2 no irq", {31'b0, irq_o}, 32'h0);
    rd(2'd0, "R1 pending visible while masked");

    // R5 routing
    req_i = 32'h10; cyc();
    check("R5 fiq route", {30'b0, irq_o, fiq_o}, 32'h1);
    req_i = 32'h40; cyc();
    check("R5 irq route", {30'b0, irq_o, fiq_o}, 32'h2);

    // R9 request needs one edge
    req_i = 32'h50; #1;
    check("R9 no change before edge", {30'b0, irq_o, fiq_o}, 32'h2);
    cyc();
    check("R9 after edge", {30'b0, irq_o, fiq_o}, 32'h3);

    // R3 idle bypass
    req_i = 32'h1; cyc();
    check("R3 pre-idle", {31'b0, irq_o}, 32'h0);
    idle_i = 1'b1; #1;
    check("R3 idle wake irq", {31'b0, irq_o}, 32'h1);
    check_out("R3 idle");

    // R4 control bit keeps mask in idle
    wr(2'd3, 32'hFFFF_FFFF);
    rd(2'd3, "R6 ctrl upper bits zero");
    check("R4 masked in idle", {30'b0, irq_o, fiq_o}, 32'h0);
    idle_i = 1'b0;

    // R7 write to pending ignored
    req_i = 32'h0; cyc();
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, "R7 pending write ignored");
    check("R7 no output after pending write", {30'b0, irq_o, fiq_o}, 32'h0);

    // R6 no read gives zero
    cyc();
    check("R6 rdata zero without read", rdata_o, 32'h0);

    // random mix
    void'($urandom(32'd1234));
    for (int i = 0; i < 400; i++) begin
      int k;
      req_i  = $urandom();
      if ($urandom_range(0, 1) == 0) req_i = req_i & $urandom() & $urandom();
      idle_i = $urandom_range(0, 1);
      k = $urandom_range(0, 9);
      if (k == 0) wr(2'd1, $urandom());
      else if (k == 1) wr(2'd2, $urandom());
      else if (k == 2) wr(2'd3, $urandom());
      else if (k == 3) rd(2'($urandom_range(0, 3)), "R6 random read");
      else cyc();
      check_out(m_dim ? "R4 random" : "R3 random");
      if (i % 50 == 0) check_out("R2 random");
    end

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule